// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Status

This block recovers 8-bit characters from an asynchronous serial line. A free-running enable pulse at sixteen times the bit rate drives it. The line passes through a short synchroniser. A state machine then finds a falling edge and confirms the start bit at its centre. It samples each following bit at its centre, sixteen enable pulses after the previous sample. A finished character goes into a holding register. Four status flags travel with it: ready, overrun, parity error and framing error.

The owning logic reads the character and sees the flags on plain output ports. A one-cycle read strobe marks that the character was taken. A control write whose reset-status bit is 1 clears the three error flags. A 3-bit mode input selects one of five parity rules. It must stay constant while a character is on the line.

The receiver state machine has six named states:
- `RX_IDLE` waits for the line to go low.
- `RX_START` confirms the start bit at its centre.
- `RX_DATA` collects the data bits.
- `RX_PARITY` samples the parity bit.
- `RX_STOP` samples the stop bit.
- `RX_BREAK` waits for the line to return high after a bad stop bit.

Its transitions are:
- `RX_IDLE` goes to `RX_START` on an enable pulse while the line is low.
- `RX_START` returns to `RX_IDLE` (glitch) or advances to `RX_DATA` at the start-bit centre.
- `RX_DATA` advances to `RX_PARITY` or `RX_STOP` after the eighth data sample.
- `RX_PARITY` advances to `RX_STOP` after its sample.
- `RX_STOP` returns to `RX_IDLE` (stop bit high) or goes to `RX_BREAK` (stop bit low).
- `RX_BREAK` returns to `RX_IDLE` once the line is high.

Top module: `serial_rx_status`

## Requirements
- R1: A frame is one low start bit, then 8 data bits with bit 0 first, then a parity bit when parity is enabled, then a stop bit. At the centre of the stop bit the character is copied to `rx_data` and `rx_ready` is set. `rx_data` changes at no other time.
- R2: Bits are sampled at their centre, counted in `baud_tick` pulses at 16 per bit. A low level that has returned high by the start-bit centre (8th pulse) is discarded and produces no character.
- R3: A character that completes while `rx_ready` is set and no read strobe is present sets `rx_overrun`. The new character replaces the held one.
- R4: `rd_strobe` clears `rx_ready` and leaves `rx_data` and all error flags unchanged. A read in the same cycle as a completion leaves `rx_ready` set and causes no overrun.
- R5: `par_mode` encodings:
    - 0 is even parity; an error is flagged when the parity bit differs from the XOR of the data bits.
    - 1 is odd parity; an error is flagged when the parity bit equals that XOR.
    - 2 is space; an error is flagged when the parity bit is 1.
    - 3 is mark; an error is flagged when the parity bit is 0.
    - 4 to 7 disable parity: no parity bit is expected and `rx_parity_err` is never set.
- R6: A stop bit sampled low sets `rx_frame_err`. The receiver then waits for the line to go high before it looks for the next start bit.
- R7: `ctrl_wr` with `ctrl_rst_status`=1 clears `rx_overrun`, `rx_parity_err` and `rx_frame_err`. `ctrl_wr` with `ctrl_rst_status`=0 changes nothing. If a completion in the same cycle raises a flag, that flag ends up set.
- R8: After reset, `rx_data` is 0 and all four flags are 0.
- R9: The overrun, parity and framing flags stay set across later error-free characters until a reset-status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Enable pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| par_mode | input | 3 | Parity rule (see R5) |
| rd_strobe | input | 1 | Holding register has been read |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_rst_status | input | 1 | Reset-status bit of the control write |
| rx_data | output | 8 | Received character |
| rx_ready | output | 1 | Unread character present |
| rx_overrun | output | 1 | Character lost to overrun |
| rx_parity_err | output | 1 | Parity error seen |
| rx_frame_err | output | 1 | Framing error seen |

## Verification
Two functions can fall in the same cycle: a character completing at the stop-bit centre, and a read strobe or reset-status write issued by the owner. The bench first measures, from the ready port, how many cycles after frame start the completion lands. It then sends further frames with a read strobe or a reset-status write placed exactly on that edge. The read collision must leave `rx_ready` set, `rx_overrun` clear and the new character held. The reset collision, with a bad parity bit in the frame, must leave `rx_parity_err` set while an older framing error is cleared.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE   = 3'd0,
        RX_START  = 3'd1,
        RX_DATA   = 3'd2,
        RX_PARITY = 3'd3,
        RX_STOP   = 3'd4,
        RX_BREAK  = 3'd5
    } rx_state_e;

    typedef enum logic [2:0] {
        PAR_EVEN  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_SPACE = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_NONE  = 3'd4
    } par_mode_e;

    typedef struct packed {
        logic ready;
        logic overrun;
        logic parity_err;
        logic frame_err;
    } rx_flags_t;

    // Modes 4..7 all disable the parity bit.
    function automatic logic parity_used(input logic [2:0] mode);
        return !mode[2];
    endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= 1'b1;
                else        stage_q[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= 1'b1;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/serial_rx_fsm.sv
module serial_rx_fsm
    import serial_rx_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rxd_s,
    input  logic                 par_used,
    output logic [DATA_BITS-1:0] shift_q,
    output logic                 par_q,
    output logic                 done,
    output logic                 stop_bad
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam int BW = $clog2(DATA_BITS);
    localparam logic [CW-1:0] MID_CNT  = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(OVERSAMPLE - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

    rx_state_e     state_q, state_d;
    logic [CW-1:0] os_q;
    logic [BW-1:0] bit_q;
    logic          mid_hit, bit_hit;

    assign mid_hit = tick && (os_q == MID_CNT);
    assign bit_hit = tick && (os_q == LAST_CNT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (tick && !rxd_s) state_d = RX_START;
            RX_START:  if (mid_hit) state_d = rxd_s ? RX_IDLE : RX_DATA;
            RX_DATA:   if (bit_hit && bit_q == LAST_BIT)
                           state_d = par_used ? RX_PARITY : RX_STOP;
            RX_PARITY: if (bit_hit) state_d = RX_STOP;
            RX_STOP:   if (bit_hit) state_d = rxd_s ? RX_IDLE : RX_BREAK;
            RX_BREAK:  if (rxd_s) state_d = RX_IDLE;
            default:   state_d = RX_IDLE;
        endcase
    end

    // Oversample counter, bit index, shift and parity capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_q    <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            par_q   <= 1'b0;
        end else begin
            if (state_q == RX_IDLE || state_q == RX_BREAK) begin
                os_q <= '0;
            end else if (tick) begin
                if ((state_q == RX_START) ? mid_hit : bit_hit) os_q <= '0;
                else                                           os_q <= os_q + CW'(1);
            end

            if (state_q != RX_DATA)  bit_q <= '0;
            else if (bit_hit)        bit_q <= bit_q + BW'(1);

            if (state_q == RX_DATA && bit_hit)
                shift_q <= {rxd_s, shift_q[DATA_BITS-1:1]};

            if (state_q == RX_PARITY && bit_hit)
                par_q <= rxd_s;
        end
    end

    // Outputs
    always_comb begin
        done     = (state_q == RX_STOP) && bit_hit;
        stop_bad = done && !rxd_s;
    end
endmodule

// File: rtl/serial_rx_parchk.sv
module serial_rx_parchk
    import serial_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic [2:0]           mode,
    input  logic [DATA_BITS-1:0] data,
    input  logic                 pbit,
    output logic                 err
);
    logic even_bit;
    assign even_bit = ^data;

    always_comb begin
        case (mode)
            PAR_EVEN:  err = (pbit != even_bit);
            PAR_ODD:   err = (pbit == even_bit);
            PAR_SPACE: err = pbit;
            PAR_MARK:  err = !pbit;
            default:   err = 1'b0;
        endcase
    end
endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags
    import serial_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] din,
    input  logic                 par_bad,
    input  logic                 stop_bad,
    input  logic                 rd,
    input  logic                 clr,
    output logic [DATA_BITS-1:0] hold_q,
    output rx_flags_t            flags_q
);
    logic ovr_set;
    assign ovr_set = done && flags_q.ready && !rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            flags_q <= '0;
        end else begin
            if (done) hold_q <= din;
            flags_q.ready      <= done | (flags_q.ready & ~rd);
            flags_q.overrun    <= ovr_set | (flags_q.overrun & ~clr);
            flags_q.parity_err <= (done & par_bad) | (flags_q.parity_err & ~clr);
            flags_q.frame_err  <= stop_bad | (flags_q.frame_err & ~clr);
        end
    end
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
    import serial_rx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 baud_tick,
    input  logic                 rxd,
    input  logic [2:0]           par_mode,
    input  logic                 rd_strobe,
    input  logic                 ctrl_wr,
    input  logic                 ctrl_rst_status,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_ready,
    output logic                 rx_overrun,
    output logic                 rx_parity_err,
    output logic                 rx_frame_err
);
    logic                 rxd_s;
    logic [DATA_BITS-1:0] shift_q;
    logic                 par_q, frame_done, stop_bad, par_err;
    rx_flags_t            flags;

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
    );

    serial_rx_fsm #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd_s(rxd_s),
        .par_used(parity_used(par_mode)), .shift_q(shift_q), .par_q(par_q),
        .done(frame_done), .stop_bad(stop_bad)
    );

    serial_rx_parchk #(.DATA_BITS(DATA_BITS)) u_par (
        .mode(par_mode), .data(shift_q), .pbit(par_q), .err(par_err)
    );

    serial_rx_flags #(.DATA_BITS(DATA_BITS)) u_flags (
        .clk(clk), .rst_n(rst_n), .done(frame_done), .din(shift_q),
        .par_bad(par_err), .stop_bad(stop_bad), .rd(rd_strobe),
        .clr(ctrl_wr && ctrl_rst_status), .hold_q(rx_data), .flags_q(flags)
    );

    assign rx_ready      = flags.ready;
    assign rx_overrun    = flags.overrun;
    assign rx_parity_err = flags.parity_err;
    assign rx_frame_err  = flags.frame_err;
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_done,
    input logic [2:0]           par_mode,
    input logic                 rd_strobe,
    input logic                 ctrl_wr,
    input logic                 ctrl_rst_status,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_ready,
    input logic                 rx_overrun,
    input logic                 rx_parity_err,
    input logic                 rx_frame_err
);
    logic clr;
    assign clr = ctrl_wr && ctrl_rst_status;

    assert_ready_on_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> rx_ready);

    assert_data_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(rx_data));

    assert_overrun_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rx_ready && !rd_strobe) |=> rx_overrun);

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !frame_done) |=> !rx_ready);

    assert_no_parity_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && par_mode[2] && !rx_parity_err) |=> !rx_parity_err);

    assert_status_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !frame_done) |=> (!rx_overrun && !rx_parity_err && !rx_frame_err));

    assert_sticky_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame_err && !clr) |=> rx_frame_err);

    assert_sticky_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !clr) |=> rx_overrun);
endmodule

bind serial_rx_status serial_rx_checker #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .par_mode(par_mode),
    .rd_strobe(rd_strobe), .ctrl_wr(ctrl_wr), .ctrl_rst_status(ctrl_rst_status),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
    .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err)
);

// File: tb/test_serial_rx_status.sv
module test_serial_rx_status;
    localparam int BITCLK = 32;   // 16 ticks, one tick every 2 clocks

    logic       clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, rxd = 1'b1;
    logic [2:0] par_mode = 3'd0;
    logic       rd_strobe = 1'b0, ctrl_wr = 1'b0, ctrl_rst_status = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, rx_overrun, rx_parity_err, rx_frame_err;

    int total = 0, bad = 0, cyc = 0, frame_t0 = 0, lat = 0;
    logic [7:0] e_data = 8'h00;
    logic e_ready = 0, e_ovr = 0, e_pe = 0, e_fe = 0;
    event ev_start;

    serial_rx_status i_serial_rx_status (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd), .par_mode(par_mode),
        .rd_strobe(rd_strobe), .ctrl_wr(ctrl_wr), .ctrl_rst_status(ctrl_rst_status),
        .rx_data(rx_data), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            @(negedge clk);
            baud_tick = ~baud_tick;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic good_pbit(input logic [7:0] d, input logic [2:0] m);
        case (m)
            3'd0:    return ^d;
            3'd1:    return ~^d;
            3'd2:    return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " data"},   32'(rx_data), 32'(e_data));
        chk({tag, " ready"},  32'(rx_ready), 32'(e_ready));
        chk({tag, " ovr"},    32'(rx_overrun), 32'(e_ovr));
        chk({tag, " parity"}, 32'(rx_parity_err), 32'(e_pe));
        chk({tag, " frame"},  32'(rx_frame_err), 32'(e_fe));
    endtask

    // Sends one frame; updates the reference model for a completion.
    task automatic send_frame(input logic [7:0] d, input logic [2:0] m,
                              input logic flip_par, input logic bad_stop);
        logic pb;
        @(negedge clk);
        while (cyc % 2 != 0) @(negedge clk);
        par_mode = m;
        frame_t0 = cyc;
        -> ev_start;
        rxd = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (BITCLK) @(negedge clk);
        end
        pb = good_pbit(d, m) ^ flip_par;
        if (!m[2]) begin
            rxd = pb;
            repeat (BITCLK) @(negedge clk);
        end
        rxd = !bad_stop;
        repeat (BITCLK) @(negedge clk);
        rxd = 1'b1;
        repeat (BITCLK) @(negedge clk);
        e_ovr  = e_ovr | e_ready;
        e_ready = 1'b1;
        e_data  = d;
        e_pe    = e_pe | (!m[2] && (pb != good_pbit(d, m)));
        e_fe    = e_fe | bad_stop;
    endtask

    task automatic do_read();
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
        e_ready = 1'b0;
    endtask

    task automatic do_ctrl(input logic rst_bit);
        ctrl_wr = 1'b1; ctrl_rst_status = rst_bit;
        @(negedge clk);
        ctrl_wr = 1'b0; ctrl_rst_status = 1'b0;
        @(negedge clk);
        if (rst_bit) begin e_ovr = 0; e_pe = 0; e_fe = 0; end
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        check_all("R8 reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_all("R8 after release");

        send_frame(8'h41, 3'd0, 0, 0);   check_all("R1 R5 even good");
        do_read();                       check_all("R4 read clears ready");
        send_frame(8'h41, 3'd1, 1, 0);   check_all("R5 odd bad");
        do_ctrl(1'b0);                   check_all("R7 write without reset bit");
        do_ctrl(1'b1);                   check_all("R7 reset status");
        send_frame(8'h3C, 3'd3, 1, 0);   check_all("R5 mark bad");
        do_ctrl(1'b1);
        send_frame(8'hA5, 3'd2, 1, 0);   check_all("R5 space bad");
        do_ctrl(1'b1);
        send_frame(8'h81, 3'd2, 0, 0);   check_all("R5 space good");
        send_frame(8'h7E, 3'd5, 0, 0);   check_all("R5 none");
        do_ctrl(1'b1); do_read();
        send_frame(8'hC3, 3'd4, 0, 1);   check_all("R6 bad stop");
        do_read();
        send_frame(8'h5A, 3'd4, 0, 0);   check_all("R6 R9 next frame, sticky frame err");
        send_frame(8'h99, 3'd0, 0, 0);   check_all("R3 overrun keeps newest");
        do_read();                       check_all("R4 read leaves overrun");
        do_ctrl(1'b1);                   check_all("R7 clear all");

        // Glitch on the line shorter than half a bit (R2)
        @(negedge clk);
        rxd = 1'b0; repeat (8) @(negedge clk); rxd = 1'b1;
        repeat (16 * BITCLK) @(negedge clk);
        check_all("R2 glitch rejected");

        // Measure the completion latency from the ready port
        fork
            send_frame(8'h12, 3'd0, 0, 0);
            begin
                @(ev_start);
                while (rx_ready !== 1'b1) @(negedge clk);
                lat = cyc - frame_t0;
            end
        join
        check_all("R1 calibration frame");

        // Read strobe on the completion edge (R4)
        fork
            send_frame(8'h34, 3'd0, 0, 0);
            begin
                @(ev_start);
                while (cyc != frame_t0 + lat - 1) @(negedge clk);
                rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
            end
        join
        e_ovr = 1'b0;   // old character was consumed in that cycle
        check_all("R4 read collides with completion");

        // Reset-status on the completion edge with a parity error (R7)
        send_frame(8'h56, 3'd4, 0, 1);
        do_read();
        fork
            send_frame(8'h78, 3'd0, 1, 0);
            begin
                @(ev_start);
                while (cyc != frame_t0 + lat - 1) @(negedge clk);
                ctrl_wr = 1'b1; ctrl_rst_status = 1'b1;
                @(negedge clk);
                ctrl_wr = 1'b0; ctrl_rst_status = 1'b0;
            end
        join
        e_ovr = 1'b0; e_fe = 1'b0; e_pe = 1'b1;
        check_all("R7 reset collides with completion");
        do_ctrl(1'b1); do_read();

        // Random traffic (R1 R3 R5 R6 R9)
        for (int n = 0; n < 30; n++) begin
            logic [7:0] d;
            logic [2:0] m;
            d = 8'($urandom);
            m = 3'($urandom % 8);
            send_frame(d, m, ($urandom % 4) == 0, ($urandom % 6) == 0);
            check_all("R1 R3 R5 R6 R9 random frame");
            if ($urandom % 2 == 0) begin do_read(); check_all("R4 random read"); end
            if ($urandom % 3 == 0) begin do_ctrl(1'b1); check_all("R7 random reset"); end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule